// File: doc/BRIEF.md
# Hypervisor Interrupt Control Register Bank

This block keeps the hypervisor-level interrupt control state for a single hart. It holds four writable registers: a virtual-pending register, an enable register, a delegation register and a guest-external enable register. It also presents two read-only views. One is the vector of guest external interrupt lines. The other is a computed pending register. From these it derives the four virtual-supervisor-level pending signals that the trap logic of the core uses.

Software reaches the bank through a plain CSR port: a 12-bit address, write data and a write enable. A write takes effect at the next rising clock edge. The read data is combinational for the address presented. No data flows as a stream through this block, so the port has no handshake and every pin is a plain control or status signal.

Two parameters shape the bank. `XLEN` is the register width, at most 64. `GEILEN` is the number of guest external interrupt lines, and it must be smaller than `XLEN`. Line `k` of the input vector (counting from 0) appears at register bit `k+1`. Bit 0 is never used.

Top module: `hv_irq_csr_bank`

## Requirements
- R1: After reset every writable bit is 0. With all interrupt inputs low, every register read returns 0 and `hip_o` is 0.
- R2: The register addresses are 0x603 (delegation), 0x604 (enable), 0x607 (guest enable), 0x608 (pending view), 0x645 (virtual pending) and 0xE12 (guest pending view). Any other address reads 0, and a write to it changes no register. A write is visible on the next read after the rising edge that samples it.
- R3: In the delegation register only bits 2, 6 and 10 can be written. All other bits, including 1, 5, 9 and 12, read 0.
- R4: In the enable register only bits 2, 6, 10 and 12 can be written. All other bits, including 15:13, read 0.
- R5: In the guest enable register only bits GEILEN:1 can be written. Bit 0 and every bit above GEILEN read 0.
- R6: The guest pending view at 0xE12 shows input line k at bit k+1, for k from 0 to GEILEN-1. All other bits read 0, and writes to this address are ignored.
- R7: In the virtual pending register only bits 2, 6 and 10 can be written. All other bits read 0.
- R8: Pending bit 12 (`sgei_pend_o`) is 1 exactly when the bitwise AND of the guest pending view and the guest enable register is nonzero.
- R9: Pending bit 10 (`vsei_pend_o`) is the OR of three terms: virtual pending bit 10, the guest pending bit selected by `vgein_i`, and `vs_ext_irq_i`. The guest enable register does not mask the selected term.
- R10: A `vgein_i` value of 0, or a value above GEILEN, selects nothing and contributes 0 to pending bit 10.
- R11: Pending bit 6 (`vsti_pend_o`) is virtual pending bit 6 OR `vs_timer_irq_i`. Pending bit 2 (`vssi_pend_o`) equals virtual pending bit 2.
- R12: A write to the pending view at 0x608 copies write-data bit 2 into virtual pending bit 2 and ignores every other bit.
- R13: `hip_o` and a read of 0x608 carry the four pending signals at bits 12, 10, 6 and 2. Every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| csr_addr_i | input | 12 | CSR address for reads and writes |
| csr_wdata_i | input | XLEN | Write data |
| csr_we_i | input | 1 | Write enable, sampled at the rising edge |
| csr_rdata_o | output | XLEN | Combinational read data for `csr_addr_i` |
| guest_ext_irq_i | input | max(GEILEN,1) | Guest external interrupt lines; line k maps to bit k+1 |
| vgein_i | input | 6 | Selects the guest line that feeds pending bit 10 |
| vs_timer_irq_i | input | 1 | External timer interrupt directed at the virtual supervisor level |
| vs_ext_irq_i | input | 1 | Other external interrupt directed at the virtual supervisor level |
| hip_o | output | XLEN | Computed pending register value |
| sgei_pend_o | output | 1 | Guest external interrupt pending (bit 12) |
| vsei_pend_o | output | 1 | Virtual supervisor external interrupt pending (bit 10) |
| vsti_pend_o | output | 1 | Virtual supervisor timer interrupt pending (bit 6) |
| vssi_pend_o | output | 1 | Virtual supervisor software interrupt pending (bit 2) |

## Verification
The bench sweeps every pair of guest line pattern and guest enable pattern, and every `vgein_i` value against every guest pattern. A bank that let the enables gate the selected line, or that indexed past GEILEN, would show a spurious or missing bit 10. One that used an OR instead of an AND reduction would raise bit 12 with nothing enabled. All-ones writes to every address expose any bit that should stay 0, such as bit 0 of the guest enable or bit 12 of the delegation register. Writes to 0x608, 0xE12 and an unused address check that only bit 2 leaks through, and only into the virtual pending register. A bank that stored the rest would read back a changed value.

// File: rtl/hv_irq_pkg.sv
package hv_irq_pkg;
  localparam logic [11:0] ADDR_DELEG = 12'h603;
  localparam logic [11:0] ADDR_IE    = 12'h604;
  localparam logic [11:0] ADDR_GIE   = 12'h607;
  localparam logic [11:0] ADDR_IP    = 12'h608;
  localparam logic [11:0] ADDR_VIP   = 12'h645;
  localparam logic [11:0] ADDR_GIP   = 12'hE12;

  localparam int BIT_SSI = 2;
  localparam int BIT_TI  = 6;
  localparam int BIT_EI  = 10;
  localparam int BIT_GEI = 12;

  localparam logic [63:0] VS_TRIO_MASK = (64'd1 << BIT_SSI) | (64'd1 << BIT_TI) | (64'd1 << BIT_EI);
  localparam logic [63:0] IE_MASK      = VS_TRIO_MASK | (64'd1 << BIT_GEI);
  localparam logic [63:0] IP_WR_MASK   = (64'd1 << BIT_SSI);

  function automatic logic [63:0] gei_mask(input int geilen);
    logic [63:0] m;
    m = '0;
    for (int i = 1; i <= geilen; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hv_irq_reg.sv
module hv_irq_reg #(
  parameter int          W     = 64,
  parameter logic [63:0] WMASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] bmask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] FIXED_MASK = WMASK[W-1:0];
  logic [W-1:0] en;
  assign en = bmask_i & FIXED_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (we_i) q_o <= (q_o & ~en) | (wdata_i & en);
  end
endmodule

// File: rtl/hv_irq_gei.sv
module hv_irq_gei #(
  parameter int XLEN   = 64,
  parameter int GEILEN = 8,
  parameter int VW     = 6,
  localparam int GLW   = (GEILEN > 0) ? GEILEN : 1
) (
  input  logic [GLW-1:0]  lines_i,
  input  logic [XLEN-1:0] gie_i,
  input  logic [VW-1:0]   vgein_i,
  output logic [XLEN-1:0] gip_o,
  output logic            any_o,
  output logic            sel_o
);
  generate
    if (GEILEN == 0) begin : g_none
      assign gip_o = '0;
      assign any_o = 1'b0;
      assign sel_o = 1'b0;
    end else begin : g_lines
      always_comb begin
        gip_o = '0;
        gip_o[GEILEN:1] = lines_i;
      end
      assign any_o = |(gip_o & gie_i);
      always_comb begin
        sel_o = 1'b0;
        for (int i = 1; i <= GEILEN; i++)
          if (vgein_i == VW'(i)) sel_o = lines_i[i-1];
      end
    end
  endgenerate
endmodule

// File: rtl/hv_irq_pend.sv
module hv_irq_pend
  import hv_irq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] vip_i,
  input  logic            gei_any_i,
  input  logic            gei_sel_i,
  input  logic            timer_i,
  input  logic            ext_i,
  output logic [XLEN-1:0] ip_o,
  output logic            sgei_o,
  output logic            vsei_o,
  output logic            vsti_o,
  output logic            vssi_o
);
  assign sgei_o = gei_any_i;
  assign vsei_o = vip_i[BIT_EI] | gei_sel_i | ext_i;
  assign vsti_o = vip_i[BIT_TI] | timer_i;
  assign vssi_o = vip_i[BIT_SSI];

  always_comb begin
    ip_o          = '0;
    ip_o[BIT_GEI] = sgei_o;
    ip_o[BIT_EI]  = vsei_o;
    ip_o[BIT_TI]  = vsti_o;
    ip_o[BIT_SSI] = vssi_o;
  end
endmodule

// File: rtl/hv_irq_csr_bank.sv
module hv_irq_csr_bank
  import hv_irq_pkg::*;
#(
  parameter int  XLEN   = 64,
  parameter int  GEILEN = 8,
  localparam int GLW    = (GEILEN > 0) ? GEILEN : 1,
  localparam int VW     = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            csr_we_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic [GLW-1:0]  guest_ext_irq_i,
  input  logic [VW-1:0]   vgein_i,
  input  logic            vs_timer_irq_i,
  input  logic            vs_ext_irq_i,
  output logic [XLEN-1:0] hip_o,
  output logic            sgei_pend_o,
  output logic            vsei_pend_o,
  output logic            vsti_pend_o,
  output logic            vssi_pend_o
);
  localparam logic [XLEN-1:0] ALL1     = '1;
  localparam logic [XLEN-1:0] IP_WMASK = IP_WR_MASK[XLEN-1:0];

  logic [XLEN-1:0] hideleg_q, hie_q, hgeie_q, hvip_q, hgeip_w;
  logic sel_deleg, sel_ie, sel_gie, sel_ip, sel_vip, sel_gip;
  logic gei_any, gei_sel, vip_we;
  logic [XLEN-1:0] vip_bmask;

  assign sel_deleg = csr_addr_i == ADDR_DELEG;
  assign sel_ie    = csr_addr_i == ADDR_IE;
  assign sel_gie   = csr_addr_i == ADDR_GIE;
  assign sel_ip    = csr_addr_i == ADDR_IP;
  assign sel_vip   = csr_addr_i == ADDR_VIP;
  assign sel_gip   = csr_addr_i == ADDR_GIP;

  // the pending view forwards only its software bit into the virtual pending register
  assign vip_we    = csr_we_i & (sel_vip | sel_ip);
  assign vip_bmask = sel_vip ? ALL1 : IP_WMASK;

  hv_irq_reg #(.W(XLEN), .WMASK(VS_TRIO_MASK)) u_deleg (
    .clk_i, .rst_ni, .we_i(csr_we_i & sel_deleg), .bmask_i(ALL1),
    .wdata_i(csr_wdata_i), .q_o(hideleg_q));

  hv_irq_reg #(.W(XLEN), .WMASK(IE_MASK)) u_ie (
    .clk_i, .rst_ni, .we_i(csr_we_i & sel_ie), .bmask_i(ALL1),
    .wdata_i(csr_wdata_i), .q_o(hie_q));

  hv_irq_reg #(.W(XLEN), .WMASK(gei_mask(GEILEN))) u_gie (
    .clk_i, .rst_ni, .we_i(csr_we_i & sel_gie), .bmask_i(ALL1),
    .wdata_i(csr_wdata_i), .q_o(hgeie_q));

  hv_irq_reg #(.W(XLEN), .WMASK(VS_TRIO_MASK)) u_vip (
    .clk_i, .rst_ni, .we_i(vip_we), .bmask_i(vip_bmask),
    .wdata_i(csr_wdata_i), .q_o(hvip_q));

  hv_irq_gei #(.XLEN(XLEN), .GEILEN(GEILEN), .VW(VW)) u_gei (
    .lines_i(guest_ext_irq_i), .gie_i(hgeie_q), .vgein_i(vgein_i),
    .gip_o(hgeip_w), .any_o(gei_any), .sel_o(gei_sel));

  hv_irq_pend #(.XLEN(XLEN)) u_pend (
    .vip_i(hvip_q), .gei_any_i(gei_any), .gei_sel_i(gei_sel),
    .timer_i(vs_timer_irq_i), .ext_i(vs_ext_irq_i), .ip_o(hip_o),
    .sgei_o(sgei_pend_o), .vsei_o(vsei_pend_o),
    .vsti_o(vsti_pend_o), .vssi_o(vssi_pend_o));

  always_comb begin
    unique case (1'b1)
      sel_deleg: csr_rdata_o = hideleg_q;
      sel_ie:    csr_rdata_o = hie_q;
      sel_gie:   csr_rdata_o = hgeie_q;
      sel_ip:    csr_rdata_o = hip_o;
      sel_vip:   csr_rdata_o = hvip_q;
      sel_gip:   csr_rdata_o = hgeip_w;
      default:   csr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hv_irq_csr_bank_chk.sv
module hv_irq_csr_bank_chk #(
  parameter int  XLEN   = 64,
  parameter int  GEILEN = 8,
  localparam int GLW    = (GEILEN > 0) ? GEILEN : 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            csr_we_i,
  input logic [11:0]     csr_addr_i,
  input logic [GLW-1:0]  guest_ext_irq_i,
  input logic            vs_timer_irq_i,
  input logic            vs_ext_irq_i,
  input logic            sgei_pend_o,
  input logic            vsei_pend_o,
  input logic            vsti_pend_o,
  input logic            vssi_pend_o,
  input logic [XLEN-1:0] hideleg_q,
  input logic [XLEN-1:0] hgeie_q,
  input logic [XLEN-1:0] hvip_q
);
  AST_DELEG_RO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hideleg_q & ~XLEN'(64'h444)) == '0); // R3
  AST_GIE_BIT0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hgeie_q[0] == 1'b0); // R5
  AST_VIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_we_i && (csr_addr_i == 12'h645 || csr_addr_i == 12'h608)) |=> $stable(hvip_q)); // R7
  AST_NO_GUEST_NO_SGEI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guest_ext_irq_i == '0 || GEILEN == 0) |-> !sgei_pend_o); // R8
  AST_EXT_RAISES_VSEI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_ext_irq_i |-> vsei_pend_o); // R9
  AST_TIMER_RAISES_VSTI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_timer_irq_i |-> vsti_pend_o); // R11
  AST_VSSI_TRACKS_VIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vssi_pend_o == hvip_q[2]); // R11
endmodule

bind hv_irq_csr_bank hv_irq_csr_bank_chk #(.XLEN(XLEN), .GEILEN(GEILEN)) u_chk (
  .clk_i, .rst_ni, .csr_we_i, .csr_addr_i, .guest_ext_irq_i,
  .vs_timer_irq_i, .vs_ext_irq_i, .sgei_pend_o, .vsei_pend_o,
  .vsti_pend_o, .vssi_pend_o, .hideleg_q, .hgeie_q, .hvip_q);

// File: tb/hv_irq_csr_bank_tb.sv
module hv_irq_csr_bank_tb;
  localparam int XLEN = 32;
  localparam int GL   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [XLEN-1:0] wdata = '0;
  logic we = 1'b0;
  logic [XLEN-1:0] rdata, hip;
  logic [GL-1:0] glines = '0;
  logic [5:0] vgein = '0;
  logic tmr = 1'b0, ext = 1'b0;
  logic sgei, vsei, vsti, vssi;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  hv_irq_csr_bank #(.XLEN(XLEN), .GEILEN(GL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .csr_we_i(we), .csr_rdata_o(rdata), .guest_ext_irq_i(glines),
    .vgein_i(vgein), .vs_timer_irq_i(tmr), .vs_ext_irq_i(ext), .hip_o(hip),
    .sgei_pend_o(sgei), .vsei_pend_o(vsei), .vsti_pend_o(vsti), .vssi_pend_o(vssi));

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [XLEN-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [XLEN-1:0] exp_hip(input logic [XLEN-1:0] vip, input logic [GL-1:0] g,
      input logic [XLEN-1:0] gie, input int v, input logic t, input logic e);
    logic [XLEN-1:0] gip, r;
    logic sel;
    gip = XLEN'(g) * 2;
    sel = (v >= 1 && v <= GL) ? g[v-1] : 1'b0;
    r = '0;
    r[12] = (gip & gie) != 0;
    r[10] = vip[10] | sel | e;
    r[6]  = vip[6] | t;
    r[2]  = vip[2];
    return r;
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(12'h603, r); chk("R1 deleg", r, 0);
    rd(12'h604, r); chk("R1 ie", r, 0);
    rd(12'h607, r); chk("R1 gie", r, 0);
    rd(12'h645, r); chk("R1 vip", r, 0);
    rd(12'hE12, r); chk("R1 gip", r, 0);
    rd(12'h608, r); chk("R1 ip", r, 0);
    chk("R1 hip_o", hip, 0);

    // masks under all-ones writes
    wr(12'h603, '1); rd(12'h603, r); chk("R3 deleg mask", r, 32'h444);
    wr(12'h604, '1); rd(12'h604, r); chk("R4 ie mask", r, 32'h1444);
    wr(12'h607, '1); rd(12'h607, r); chk("R5 gie mask", r, 32'h1E);
    wr(12'h645, '1); rd(12'h645, r); chk("R7 vip mask", r, 32'h444);
    rd(12'h608, r); chk("R13 ip view", r, 32'h444);
    chk("R13 hip_o", hip, 32'h444);
    wr(12'h603, 32'h400); rd(12'h603, r); chk("R3 deleg partial", r, 32'h400);

    // R2/R6 ignored writes
    wr(12'hE12, '1); rd(12'hE12, r); chk("R6 gip write ignored", r, 0);
    wr(12'h600, '1);
    rd(12'h600, r); chk("R2 unused reads 0", r, 0);
    rd(12'h603, r); chk("R2 deleg untouched", r, 32'h400);
    rd(12'h604, r); chk("R2 ie untouched", r, 32'h1444);
    rd(12'h607, r); chk("R2 gie untouched", r, 32'h1E);
    rd(12'h645, r); chk("R2 vip untouched", r, 32'h444);

    // R12 write through pending view
    wr(12'h645, 0);
    wr(12'h608, '1); rd(12'h645, r); chk("R12 ip write sets bit2 only", r, 32'h4);
    rd(12'h604, r); chk("R12 ie untouched", r, 32'h1444);
    wr(12'h608, 32'hFFFF_FFFB); rd(12'h645, r); chk("R12 ip write clears bit2", r, 0);

    // R6/R8 sweep guest lines x guest enables
    for (int e = 0; e < 16; e++) begin
      wr(12'h607, XLEN'(e) << 1);
      for (int g = 0; g < 16; g++) begin
        glines = GL'(g);
        rd(12'hE12, r); chk("R6 gip view", r, XLEN'(g) << 1);
        chk("R8 sgei", {31'd0, sgei}, {31'd0, (g & e) != 0});
        chk("R13 hip sgei bit", hip, exp_hip(0, GL'(g), XLEN'(e) << 1, 0, 0, 0));
      end
    end

    // R9/R10 VGEIN sweep with enables cleared
    wr(12'h607, 0);
    for (int v = 0; v < 64; v++) begin
      for (int g = 0; g < 16; g++) begin
        glines = GL'(g); vgein = 6'(v);
        #1;
        chk((v == 0 || v > GL) ? "R10 vgein none" : "R9 vgein select",
            {31'd0, vsei}, {31'd0, (v >= 1 && v <= GL) ? g[v-1] : 1'b0});
      end
    end
    vgein = '0; glines = '0;

    // R11/R13 virtual pending x timer x external
    for (int s = 0; s < 8; s++) begin
      logic [XLEN-1:0] vip;
      vip = '0; vip[2] = s[0]; vip[6] = s[1]; vip[10] = s[2];
      wr(12'h645, vip);
      for (int te = 0; te < 4; te++) begin
        tmr = te[0]; ext = te[1];
        #1;
        chk("R11 hip_o", hip, exp_hip(vip, 0, 0, 0, te[0], te[1]));
        rd(12'h608, r); chk("R13 ip read", r, exp_hip(vip, 0, 0, 0, te[0], te[1]));
        chk("R11 vsti/vssi", {30'd0, vsti, vssi}, {30'd0, vip[6] | te[0], vip[2]});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule